// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block takes the fault reports of a five-stage in-order pipeline and turns them into precise exceptions. The decode stage reports an undefined opcode and the execute stage reports an arithmetic overflow. Each report comes with the program counter of the instruction that raised it. When a fault is taken, the controller does four things in the same cycle:

- it selects the oldest faulting instruction;
- it raises flush requests for that instruction and every younger one, so the pipeline zeroes their control fields;
- it stops an overflowing instruction from writing its destination register;
- it steers fetch to a handler entry.

Instructions older than the fault, which sit in the memory and writeback stages, are not touched and complete normally.

On the clock edge that takes the fault, the controller loads two registers. The saved-PC register receives the faulting address plus four, and handler software corrects for that offset. A one-bit reason register records why the fault was taken. A mode input selects the handler address. In single-entry mode every fault goes to one common handler. In vectored mode the entry depends on the reason, and entries are spaced a fixed stride apart. The saved PC is available as a read port, for use by a return-from-exception path.

Top module: `precise_exc_ctrl`

## Requirements
- R1: The reason register encodes an undefined opcode as 0 and an overflow as 1. It shows the code of the taken fault from the clock edge that takes it.
- R2: With `vec_mode` low, any taken fault drives `redirect_valid` high and `redirect_pc` to 0x80000180 in the same cycle.
- R3: With `vec_mode` high, an undefined opcode redirects to 0xC0000000 and an overflow redirects to 0xC0000020, in the same cycle.
- R4: On the clock edge that takes a fault, the saved PC becomes the faulting instruction's PC plus 4.
- R5: `ex_regwrite_out` is low whenever `ex_ovf` is high. Otherwise it follows `ex_regwrite_in`.
- R6: An overflow raises `flush_if`, `flush_id` and `flush_ex`. An undefined opcode alone raises `flush_if` and `flush_id` and leaves `flush_ex` low.
- R7: When both faults occur in the same cycle, the overflow (the older instruction) is taken. The saved PC becomes the execute-stage PC plus 4, and the reason becomes 1.
- R8: The saved PC and the reason register hold their values in every cycle without a fault.
- R9: A fault redirect overrides a branch redirect in the same cycle. With no fault, a branch redirect passes through unchanged.
- R10: After reset the saved PC and the reason are 0, and when no input is active no redirect or flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 1 selects per-reason handler entries |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage produced an overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| ex_regwrite_in | input | 1 | Register-write control of the execute-stage instruction |
| br_redirect | input | 1 | Branch unit requests a fetch redirect |
| br_target | input | 32 | Branch target address |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Next fetch address |
| flush_if | output | 1 | Zero the fetch/decode pipeline register |
| flush_id | output | 1 | Zero control entering the execute stage |
| flush_ex | output | 1 | Zero control entering the memory stage |
| ex_regwrite_out | output | 1 | Gated register-write control |
| epc_out | output | 32 | Saved PC read port |
| cause_out | output | 1 | Reason register |

## Verification
The redirect, flush and write-gating outputs are combinational. The bench changes inputs just after a falling edge and samples these outputs one nanosecond later, in the same cycle. The saved PC and the reason register change on the next rising edge. The bench samples them after the following falling edge, and it checks them again after several idle cycles to confirm that they hold.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int NUM_CAUSES = 2;
    localparam int CAUSE_W    = $clog2(NUM_CAUSES);

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_UNDEF = 1'b0,
        CAUSE_OVF   = 1'b1
    } exc_cause_e;

    typedef struct packed {
        logic             valid;
        exc_cause_e       cause;
        logic [XLEN-1:0]  pc;
    } exc_rec_t;

    function automatic logic [XLEN-1:0] pc_after(input logic [XLEN-1:0] pc,
                                                 input logic [XLEN-1:0] step);
        return pc + step;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output exc_rec_t        rec
);
    // Execute holds the older instruction, so its fault wins.
    always_comb begin
        rec = '0;
        if (ex_ovf) begin
            rec.valid = 1'b1;
            rec.cause = CAUSE_OVF;
            rec.pc    = ex_pc;
        end else if (id_undef) begin
            rec.valid = 1'b1;
            rec.cause = CAUSE_UNDEF;
            rec.pc    = id_pc;
        end
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] COMMON_ENTRY = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE     = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE   = 32'h0000_0020
) (
    input  logic            vec_mode,
    input  exc_cause_e      cause,
    output logic [XLEN-1:0] entry
);
    localparam int PAD_W = XLEN - CAUSE_W;

    logic [XLEN-1:0] idx;
    assign idx = {{PAD_W{1'b0}}, cause};

    always_comb begin
        if (vec_mode) entry = VEC_BASE + idx * VEC_STRIDE;
        else          entry = COMMON_ENTRY;
    end
endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] PC_STEP = 32'd4
) (
    input  logic            clk,
    input  logic            rst,
    input  exc_rec_t        rec,
    output logic [XLEN-1:0] epc,
    output exc_cause_e      cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            cause <= CAUSE_UNDEF;
        end else if (rec.valid) begin
            epc   <= pc_after(rec.pc, PC_STEP);
            cause <= rec.cause;
        end
    end
endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] COMMON_ENTRY = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE     = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE   = 32'h0000_0020,
    parameter logic [XLEN-1:0] PC_STEP      = 32'd4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vec_mode,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            ex_regwrite_in,
    input  logic            br_redirect,
    input  logic [XLEN-1:0] br_target,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            ex_regwrite_out,
    output logic [XLEN-1:0] epc_out,
    output logic            cause_out
);
    exc_rec_t        rec;
    logic [XLEN-1:0] entry;
    exc_cause_e      cause_q;

    exc_arbiter u_arb (
        .id_undef (id_undef),
        .id_pc    (id_pc),
        .ex_ovf   (ex_ovf),
        .ex_pc    (ex_pc),
        .rec      (rec)
    );

    exc_vector #(
        .COMMON_ENTRY (COMMON_ENTRY),
        .VEC_BASE     (VEC_BASE),
        .VEC_STRIDE   (VEC_STRIDE)
    ) u_vec (
        .vec_mode (vec_mode),
        .cause    (rec.cause),
        .entry    (entry)
    );

    exc_state #(.PC_STEP(PC_STEP)) u_state (
        .clk   (clk),
        .rst   (rst),
        .rec   (rec),
        .epc   (epc_out),
        .cause (cause_q)
    );

    assign cause_out = cause_q;

    // Fault and younger instructions are squashed; older stages proceed.
    always_comb begin
        flush_if        = rec.valid;
        flush_id        = rec.valid;
        flush_ex        = rec.valid && (rec.cause == CAUSE_OVF);
        ex_regwrite_out = ex_regwrite_in && !ex_ovf;
    end

    // A fault redirect has precedence over a branch redirect.
    always_comb begin
        if (rec.valid) begin
            redirect_valid = 1'b1;
            redirect_pc    = entry;
        end else begin
            redirect_valid = br_redirect;
            redirect_pc    = br_target;
        end
    end
endmodule

// File: rtl/precise_exc_ctrl_chk.sv
module precise_exc_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        vec_mode,
    input logic        id_undef,
    input logic [31:0] ex_pc,
    input logic        ex_ovf,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic        flush_id,
    input logic        flush_ex,
    input logic        ex_regwrite_out,
    input logic [31:0] epc_out,
    input logic        cause_out
);
    p_undef_cause_r1: assert property (@(posedge clk) disable iff (rst)
        (id_undef && !ex_ovf) |=> (cause_out == 1'b0));

    p_vec_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        (vec_mode && ex_ovf) |-> (redirect_pc == 32'hC000_0020));

    p_epc_value_r4: assert property (@(posedge clk) disable iff (rst)
        ex_ovf |=> (epc_out == $past(ex_pc) + 32'd4));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        ex_ovf |-> !ex_regwrite_out);

    p_undef_keeps_ex_r6: assert property (@(posedge clk) disable iff (rst)
        (id_undef && !ex_ovf) |-> (flush_id && !flush_ex));

    p_ovf_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ex_ovf |=> (cause_out == 1'b1));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(id_undef || ex_ovf) |=> ($stable(epc_out) && $stable(cause_out)));

    p_fault_redirect_r9: assert property (@(posedge clk) disable iff (rst)
        (id_undef || ex_ovf) |-> redirect_valid);
endmodule

bind precise_exc_ctrl precise_exc_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .vec_mode        (vec_mode),
    .id_undef        (id_undef),
    .ex_pc           (ex_pc),
    .ex_ovf          (ex_ovf),
    .redirect_valid  (redirect_valid),
    .redirect_pc     (redirect_pc),
    .flush_id        (flush_id),
    .flush_ex        (flush_ex),
    .ex_regwrite_out (ex_regwrite_out),
    .epc_out         (epc_out),
    .cause_out       (cause_out)
);

// File: tb/precise_exc_ctrl_test.sv
module precise_exc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        vec_mode, id_undef, ex_ovf, ex_regwrite_in, br_redirect;
    logic [31:0] id_pc, ex_pc, br_target;
    logic        redirect_valid, flush_if, flush_id, flush_ex, ex_regwrite_out, cause_out;
    logic [31:0] redirect_pc, epc_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    precise_exc_ctrl uut (
        .clk(clk), .rst(rst), .vec_mode(vec_mode),
        .id_undef(id_undef), .id_pc(id_pc), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .ex_regwrite_in(ex_regwrite_in), .br_redirect(br_redirect), .br_target(br_target),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
        .ex_regwrite_out(ex_regwrite_out), .epc_out(epc_out), .cause_out(cause_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        id_undef = 0; ex_ovf = 0; br_redirect = 0; ex_regwrite_in = 0;
        id_pc = 0; ex_pc = 0; br_target = 0;
    endtask

    // Inputs change after a falling edge; combinational results sampled 1 ns later.
    task automatic drive_at_negedge();
        @(negedge clk);
    endtask

    // Registered results: after the next rising edge, sampled at the falling edge.
    task automatic settle_regs();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic t_reset();
        #1;
        chk("R10 epc", epc_out, 32'h0);
        chk("R10 cause", {31'b0, cause_out}, 32'h0);
        chk("R10 redirect", {31'b0, redirect_valid}, 32'h0);
        chk("R10 flush", {29'b0, flush_if, flush_id, flush_ex}, 32'h0);
    endtask

    task automatic t_branch_only();
        drive_at_negedge();
        br_redirect = 1; br_target = 32'h100;
        #1;
        chk("R9 branch valid", {31'b0, redirect_valid}, 32'h1);
        chk("R9 branch pc", redirect_pc, 32'h100);
        chk("R9 no flush", {29'b0, flush_if, flush_id, flush_ex}, 32'h0);
        settle_regs();
        chk("R8 epc untouched by branch", epc_out, 32'h0);
    endtask

    task automatic t_undef_common();
        drive_at_negedge();
        vec_mode = 0; id_undef = 1; id_pc = 32'h40; ex_regwrite_in = 1;
        #1;
        chk("R2 undef entry", redirect_pc, 32'h8000_0180);
        chk("R6 undef flushes", {29'b0, flush_if, flush_id, flush_ex}, 32'h6);
        chk("R5 regwrite passes", {31'b0, ex_regwrite_out}, 32'h1);
        settle_regs();
        chk("R4 epc undef", epc_out, 32'h44);
        chk("R1 cause undef", {31'b0, cause_out}, 32'h0);
    endtask

    task automatic t_ovf_common();
        drive_at_negedge();
        vec_mode = 0; ex_ovf = 1; ex_pc = 32'h4C; ex_regwrite_in = 1;
        #1;
        chk("R5 regwrite killed", {31'b0, ex_regwrite_out}, 32'h0);
        chk("R6 ovf flushes", {29'b0, flush_if, flush_id, flush_ex}, 32'h7);
        chk("R2 ovf entry", redirect_pc, 32'h8000_0180);
        settle_regs();
        chk("R4 epc ovf", epc_out, 32'h50);
        chk("R1 cause ovf", {31'b0, cause_out}, 32'h1);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) @(negedge clk);
        #1;
        chk("R8 epc hold", epc_out, 32'h50);
        chk("R8 cause hold", {31'b0, cause_out}, 32'h1);
    endtask

    task automatic t_vectored();
        drive_at_negedge();
        vec_mode = 1; id_undef = 1; id_pc = 32'h80;
        #1;
        chk("R3 vec undef", redirect_pc, 32'hC000_0000);
        settle_regs();
        chk("R1 cause after vec undef", {31'b0, cause_out}, 32'h0);
        drive_at_negedge();
        ex_ovf = 1; ex_pc = 32'h90;
        #1;
        chk("R3 vec ovf", redirect_pc, 32'hC000_0020);
        settle_regs();
        chk("R4 epc vec ovf", epc_out, 32'h94);
    endtask

    task automatic t_both();
        drive_at_negedge();
        vec_mode = 0; ex_ovf = 1; ex_pc = 32'h200; id_undef = 1; id_pc = 32'h204;
        br_redirect = 1; br_target = 32'h300;
        #1;
        chk("R9 fault beats branch", redirect_pc, 32'h8000_0180);
        chk("R7 both flush ex", {31'b0, flush_ex}, 32'h1);
        settle_regs();
        chk("R7 epc oldest", epc_out, 32'h204);
        chk("R7 cause oldest", {31'b0, cause_out}, 32'h1);
    endtask

    initial begin
        fork
            begin
                #2_000_000;
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        join_none
        rst = 1; vec_mode = 0; idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_branch_only();
        t_undef_common();
        t_ovf_common();
        t_hold();
        t_vectored();
        t_both();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule